// File: doc/BRIEF.md
# Codec link startup sequencer

This block brings a serial audio codec link up in a safe order. It runs on a free-running system clock. On a start request it holds the codec's active-low reset line low for a minimum time and then releases it. It then waits for the codec to begin driving its bit clock. Only when that clock is seen to be running does it enable the receive and transmit framers. One cycle later it enables the frame-sync generator and raises `link_up`.

The bit clock arrives asynchronously. It is passed through a synchronizer and an edge detector. It is declared live after a run of consecutive toggles in which no gap between toggles exceeds a set window. A longer gap starts the run over.

If the clock does not come up within a timeout after reset release, the block raises a sticky error, puts the codec back into reset and returns to idle. A start request while the link is up tears the link down and runs the whole sequence again.

Top module: `codec_link_seq`

## Requirements
- R1: After the block's reset, `codec_rst_n`, `rx_en`, `tx_en`, `sync_en`, `link_up` and `timeout_err` are all 0.
- R2: A start request accepted in idle holds `codec_rst_n` low for exactly RST_CYC = ceil(RST_NS / CLK_NS) system-clock cycles (100 with the defaults), counted from the edge that samples the request. After that, `codec_rst_n` goes high.
- R3: The bit clock is taken as running once the synchronized clock has made EDGE_COUNT (16) consecutive toggles. Each toggle must follow the previous one within GAP_WINDOW (16) system cycles. A gap of GAP_WINDOW cycles with no toggle restarts the count from zero.
- R4: `rx_en` and `tx_en` rise together, and only while `codec_rst_n` is high, once the bit clock has been detected as running. `rx_en` rises no later than 2 toggles after the EDGE_COUNT-th toggle.
- R5: `sync_en` and `link_up` rise together exactly one cycle after the framer enables, and are never high unless both framer enables are high.
- R6: If the bit clock is not detected within TIMEOUT_CYC (600) cycles of reset release, `codec_rst_n` returns low after exactly TIMEOUT_CYC cycles high. At the same time `timeout_err` is set and all enables stay low.
- R7: `timeout_err` stays high until the next accepted start request, which clears it.
- R8: A start request while `link_up` is high drops `rx_en`, `tx_en`, `sync_en` and `link_up` and drives `codec_rst_n` low on the next cycle. The full sequence then reruns with the R2 timing.
- R9: A start request during the reset phase is ignored. The reset release still falls RST_CYC cycles after the request that began the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| start_req | input | 1 | Request to run (or rerun) the startup sequence |
| codec_bclk | input | 1 | Raw bit clock from the codec, asynchronous |
| codec_rst_n | output | 1 | Active-low reset line to the codec |
| rx_en | output | 1 | Receive framer enable |
| tx_en | output | 1 | Transmit framer enable |
| sync_en | output | 1 | Frame-sync generator enable |
| link_up | output | 1 | Link fully enabled |
| timeout_err | output | 1 | Sticky: bit clock never came up |

## Verification
A wrong state or a miscounted timer shows directly at the ports. The reset pulse comes out shorter or longer than RST_CYC, or the timeout fires at the wrong cycle count. Both are measured to the exact cycle from the request or the release. A faulty toggle counter or gap window makes the framer enables rise before EDGE_COUNT toggles, too late, or after a stalled clock. The bench counts the toggles it drove when `rx_en` first appears. A broken enable order shows within one cycle as `sync_en` rising together with or ahead of the framers.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RESET = 3'd1,
    ST_WAIT  = 3'd2,
    ST_PORTS = 3'd3,
    ST_RUN   = 3'd4
  } seq_state_t;
endpackage

// File: rtl/codec_seq_timer.sv
module codec_seq_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/codec_bclk_monitor.sv
module codec_bclk_monitor #(
  parameter int EDGE_COUNT = 16,
  parameter int GAP_WINDOW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_raw,
  input  logic enable,
  output logic live
);
  localparam int CW = $clog2(EDGE_COUNT + 1);
  localparam int GW = $clog2(GAP_WINDOW + 1);

  logic [2:0]    sync_q;
  logic          toggle;
  logic [CW-1:0] run_q, run_d;
  logic [GW-1:0] gap_q, gap_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], bclk_raw};
  end

  assign toggle = sync_q[2] ^ sync_q[1];

  always_comb begin
    run_d = run_q;
    gap_d = gap_q;
    if (!enable) begin
      run_d = '0;
      gap_d = '0;
    end else if (toggle) begin
      gap_d = '0;
      if (run_q != CW'(EDGE_COUNT)) run_d = run_q + 1'b1;
    end else if (gap_q == GW'(GAP_WINDOW - 1)) begin
      gap_d = '0;
      run_d = '0;
    end else begin
      gap_d = gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      gap_q <= '0;
    end else begin
      run_q <= run_d;
      gap_q <= gap_d;
    end
  end

  assign live = (run_q == CW'(EDGE_COUNT));
endmodule

// File: rtl/codec_link_seq.sv
module codec_link_seq
  import codec_seq_pkg::*;
#(
  parameter int RST_NS      = 1000,
  parameter int CLK_NS      = 10,
  parameter int TIMEOUT_CYC = 600,
  parameter int EDGE_COUNT  = 16,
  parameter int GAP_WINDOW  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic codec_bclk,
  output logic codec_rst_n,
  output logic rx_en,
  output logic tx_en,
  output logic sync_en,
  output logic link_up,
  output logic timeout_err
);
  localparam int RST_CYC = (RST_NS + CLK_NS - 1) / CLK_NS;
  localparam int TMAX    = (RST_CYC > TIMEOUT_CYC) ? RST_CYC : TIMEOUT_CYC;
  localparam int TW      = $clog2(TMAX + 1);

  seq_state_t    state_q, state_d;
  logic          tmr_load, tmr_done, clk_live;
  logic [TW-1:0] tmr_val;
  logic          err_set, err_clr;
  logic          rst_line_d, ports_d, sync_d;

  codec_seq_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  codec_bclk_monitor #(.EDGE_COUNT(EDGE_COUNT), .GAP_WINDOW(GAP_WINDOW)) u_mon (
    .clk(clk), .rst_n(rst_n), .bclk_raw(codec_bclk),
    .enable(state_q == ST_WAIT), .live(clk_live)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = TW'(RST_CYC - 1);
    err_set  = 1'b0;
    err_clr  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_RUN: if (start_req) begin
        state_d  = ST_RESET;
        tmr_load = 1'b1;
        err_clr  = 1'b1;
      end
      ST_RESET: if (tmr_done) begin
        state_d  = ST_WAIT;
        tmr_load = 1'b1;
        tmr_val  = TW'(TIMEOUT_CYC - 1);
      end
      ST_WAIT: begin
        if (clk_live) begin
          state_d = ST_PORTS;
        end else if (tmr_done) begin
          state_d = ST_IDLE;
          err_set = 1'b1;
        end
      end
      ST_PORTS: state_d = ST_RUN;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rst_line_d = (state_d == ST_WAIT) || (state_d == ST_PORTS) || (state_d == ST_RUN);
    ports_d    = (state_d == ST_PORTS) || (state_d == ST_RUN);
    sync_d     = (state_d == ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      codec_rst_n <= 1'b0;
      rx_en       <= 1'b0;
      tx_en       <= 1'b0;
      sync_en     <= 1'b0;
      link_up     <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      state_q     <= state_d;
      codec_rst_n <= rst_line_d;
      rx_en       <= ports_d;
      tx_en       <= ports_d;
      sync_en     <= sync_d;
      link_up     <= sync_d;
      if (err_clr)      timeout_err <= 1'b0;
      else if (err_set) timeout_err <= 1'b1;
    end
  end
endmodule

// File: rtl/codec_link_seq_chk.sv
module codec_link_seq_chk #(
  parameter int RST_NS = 1000,
  parameter int CLK_NS = 10
) (
  input logic clk,
  input logic rst_n,
  input logic start_req,
  input logic codec_rst_n,
  input logic rx_en,
  input logic tx_en,
  input logic sync_en,
  input logic link_up,
  input logic timeout_err
);
  localparam int RST_CYC = (RST_NS + CLK_NS - 1) / CLK_NS;

  logic [31:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 low_run <= '0;
    else if (codec_rst_n)       low_run <= '0;
    else if (low_run != '1)     low_run <= low_run + 1'b1;
  end

  AST_RESET_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(codec_rst_n) |-> (low_run >= 32'(RST_CYC))); // R2
  AST_PORTS_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en || tx_en) |-> codec_rst_n); // R4
  AST_PORTS_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en == tx_en); // R4
  AST_SYNC_NEEDS_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_en |-> (rx_en && tx_en)); // R5
  AST_SYNC_LAGS_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_en) |-> $past(rx_en)); // R5
  AST_LINK_WITH_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    link_up == sync_en); // R5
  AST_ERR_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (!codec_rst_n && !rx_en)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_err && !start_req) |=> timeout_err); // R7
endmodule

bind codec_link_seq codec_link_seq_chk #(.RST_NS(RST_NS), .CLK_NS(CLK_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .codec_rst_n(codec_rst_n),
  .rx_en(rx_en), .tx_en(tx_en), .sync_en(sync_en), .link_up(link_up),
  .timeout_err(timeout_err)
);

// File: tb/codec_link_seq_bench.sv
module codec_link_seq_bench;
  localparam int RST_NS = 1000, CLK_NS = 10, TOUT = 600, NEED = 16, WIN = 16;
  localparam int RCYC = (RST_NS + CLK_NS - 1) / CLK_NS;

  logic clk, rst_n, start_req, codec_bclk;
  logic codec_rst_n, rx_en, tx_en, sync_en, link_up, timeout_err;

  int checks, fails;
  int hp, tog, pause_after, pause_len;
  bit gen_on;

  codec_link_seq #(.RST_NS(RST_NS), .CLK_NS(CLK_NS), .TIMEOUT_CYC(TOUT),
                   .EDGE_COUNT(NEED), .GAP_WINDOW(WIN)) u_codec_link_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .codec_bclk(codec_bclk),
    .codec_rst_n(codec_rst_n), .rx_en(rx_en), .tx_en(tx_en), .sync_en(sync_en),
    .link_up(link_up), .timeout_err(timeout_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // codec model: bit clock runs only while its reset is released
  initial begin
    int hc, pl;
    hc = 0; pl = 0;
    forever begin
      @(negedge clk);
      if (gen_on && codec_rst_n && hp > 0) begin
        if (pl > 0) pl--;
        else begin
          hc++;
          if (hc >= hp) begin
            hc = 0;
            codec_bclk = ~codec_bclk;
            tog++;
            if (pause_after != 0 && tog == pause_after) begin
              pl = pause_len; tog = 0; pause_after = 0;
            end
          end
        end
      end else hc = 0;
    end
  end

  task automatic chk(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #2;
  endtask

  task automatic pulse_start;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
  endtask

  function automatic int exp_release_cycles(int rst_ns, int clk_ns);
    return (rst_ns + clk_ns - 1) / clk_ns;
  endfunction

  // start, measure reset width; optionally check teardown and inject a spurious start
  task automatic start_and_release(bit from_link, bit spur);
    int n;
    pulse_start();
    n = 0;
    do begin
      tick(); n++;
      if (n == 1 && from_link)
        chk("R8 teardown", !rx_en && !tx_en && !sync_en && !link_up && !codec_rst_n,
            {rx_en, sync_en, link_up, codec_rst_n}, 0);
      if (n == 1)
        chk("R7 err cleared by start", timeout_err == 1'b0, timeout_err, 0);
      if (spur && n == 20) start_req = 1'b1;
      if (n == 21) start_req = 1'b0;
    end while (!codec_rst_n && n < 1000);
    chk(spur ? "R9 spurious start ignored" : "R2 reset width", n == exp_release_cycles(RST_NS, CLK_NS), n, RCYC);
    tog = 0;
  endtask

  task automatic expect_link;
    int n;
    n = 0;
    while (!rx_en && n < 2000) begin tick(); n++; end
    chk("R3 toggles before framers", rx_en && tog >= NEED && tog <= NEED + 2, tog, NEED);
    chk("R4 framers on release", tx_en && codec_rst_n && !sync_en, {tx_en, codec_rst_n, sync_en}, 3'b110);
    tick();
    chk("R5 sync one cycle later", sync_en && link_up && rx_en, {sync_en, link_up}, 2'b11);
  endtask

  initial begin
    void'($urandom(32'd2024));
    checks = 0; fails = 0;
    fork
      begin
        int n;
        rst_n = 1'b0; start_req = 1'b0; codec_bclk = 1'b0;
        gen_on = 1'b0; hp = 4; tog = 0; pause_after = 0; pause_len = 0;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset state", {codec_rst_n, rx_en, tx_en, sync_en, link_up, timeout_err} == 6'b0,
            {codec_rst_n, rx_en, tx_en, sync_en, link_up, timeout_err}, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (5) tick();
        chk("R1 idle after reset", !codec_rst_n && !link_up, {codec_rst_n, link_up}, 0);

        // directed: normal bring-up
        gen_on = 1'b1; hp = 4;
        start_and_release(1'b0, 1'b0);
        expect_link();

        // constrained random restarts from link up
        for (int i = 0; i < 6; i++) begin
          hp = 3 + int'($urandom % 5);
          start_and_release(1'b1, 1'($urandom % 2));
          expect_link();
        end

        // gap restarts the toggle run (R3)
        hp = 3; pause_after = 10; pause_len = 40;
        start_and_release(1'b1, 1'b0);
        expect_link();

        // too slow a clock never qualifies: timeout (R6)
        hp = WIN + 4;
        start_and_release(1'b1, 1'b0);
        n = 0;
        while (codec_rst_n && n < 2000) begin
          tick(); n++;
          if (rx_en) break;
        end
        chk("R6 timeout length", n == TOUT, n, TOUT);
        chk("R6 error and reset", timeout_err && !codec_rst_n && !rx_en && !sync_en,
            {timeout_err, codec_rst_n, rx_en}, 3'b100);

        // no clock at all, then stickiness (R7)
        gen_on = 1'b0;
        repeat (50) tick();
        chk("R7 error sticky", timeout_err == 1'b1, timeout_err, 1);
        start_and_release(1'b0, 1'b0);
        n = 0;
        while (codec_rst_n && n < 2000) begin tick(); n++; end
        chk("R6 timeout with silent clock", n == TOUT && timeout_err, n, TOUT);

        // recovery after error
        gen_on = 1'b1; hp = 5;
        start_and_release(1'b0, 1'b1);
        expect_link();
      end
      begin
        repeat (150000) @(posedge clk);
        chk("watchdog", 1'b0, 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule